// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Scoreboard

This block sits in a two-wide, in-order issue stage. Each cycle it is offered up to two candidate instructions. Each candidate carries a 3-bit class code. The block decides, in the same cycle, which of them may issue without colliding with a functional unit that an earlier instruction still holds.

The machine has two memory ports and one each of integer ALU, FP adder, FP multiplier, FP divider and branch unit. Each class reserves its unit for a fixed number of consecutive cycles, starting with the issue cycle:

| Class | Unit held | Cycles |
|-------|-----------|--------|
| load | one memory port | 1 |
| store | one memory port | 3 |
| FP multiply | multiplier | 2 |
| FP divide | divider | 51 |
| ALU, FP add, branch | own unit | 1 |
| nop | issue slot only | — |

One down-counter per unit tracks the reservations. The grants and the issue count are combinational from those counters and the current candidates. The counters advance at the clock edge.

Top module: `issue_hazard_sb`

## Requirements
- R1: Class codes are NOP=0, ALU=1, LOAD=2, STORE=3, FADD=4, FMUL=5, FDIV=6, BRANCH=7. At most two instructions issue per cycle, and `issue_count` equals the number of grants asserted in that cycle.
- R2: Issue is in order. `grant1` is asserted only when `grant0` is asserted in the same cycle. A slot whose valid is low is never granted.
- R3: A valid nop is always granted and touches no unit's busy state.
- R4: A load takes the lowest-numbered free memory port for its issue cycle only. Two loads in one cycle both issue when both ports are free.
- R5: A store holds its memory port for three consecutive cycles starting at issue. The port reports busy in the two cycles after issue.
- R6: ALU, FP add and branch instructions hold their unit only in the issue cycle, so one may issue every cycle. A second candidate of the same class in the same cycle stalls.
- R7: An FP multiply holds the multiplier for two cycles. A multiply offered in the following cycle stalls, and one offered two cycles after issue is granted.
- R8: An FP divide holds the divider for 51 cycles. The next divide is granted no earlier than 51 cycles after the previous one issued.
- R9: A synchronous active-high reset clears every reservation, so all units are free in the first cycle after reset.
- R10: `unit_busy` bit positions are: 0 memory port 0, 1 memory port 1, 2 ALU, 3 FP adder, 4 FP multiplier, 5 FP divider, 6 branch. A bit is high when that unit is reserved past the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot0_valid | input | 1 | Older candidate present |
| slot0_class | input | 3 | Class code of older candidate |
| slot1_valid | input | 1 | Younger candidate present |
| slot1_class | input | 3 | Class code of younger candidate |
| grant0 | output | 1 | Older candidate issues this cycle |
| grant1 | output | 1 | Younger candidate issues this cycle |
| issue_count | output | 2 | Number of instructions issued this cycle |
| unit_busy | output | 7 | Per-unit reservation flags |

## Verification
The assertions check, on every cycle, the following properties:
- Grants stay in order.
- Nops are always granted.
- A unit is never claimed while it is still reserved.
- A reserved divider blocks divide grants.
- A store leaves a memory port busy in the next cycle.

Only the bench's scenarios can show the exact reservation lengths of 1, 2, 3 and 51 cycles. They also show which port a memory access lands on, and that a reset in the middle of a divide frees the divider. The bench checks these against an independent reservation table over directed sequences and a long random class stream.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    typedef enum logic [2:0] {
        CLS_NOP    = 3'd0,
        CLS_ALU    = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_FADD   = 3'd4,
        CLS_FMUL   = 3'd5,
        CLS_FDIV   = 3'd6,
        CLS_BRANCH = 3'd7
    } iclass_e;

    localparam int NUM_UNITS = 7;
    localparam int U_MEM0 = 0;
    localparam int U_MEM1 = 1;
    localparam int U_ALU  = 2;
    localparam int U_FADD = 3;
    localparam int U_FMUL = 4;
    localparam int U_FDIV = 5;
    localparam int U_BR   = 6;

    typedef struct packed {
        logic                 ok;
        logic [NUM_UNITS-1:0] claim;
        logic [1:0]           store_on;
    } pick_t;

    function automatic int single_unit(iclass_e c);
        case (c)
            CLS_ALU:  return U_ALU;
            CLS_FADD: return U_FADD;
            CLS_FMUL: return U_FMUL;
            CLS_FDIV: return U_FDIV;
            default:  return U_BR;
        endcase
    endfunction

endpackage

// File: rtl/hsb_unit_timer.sv
module hsb_unit_timer #(
    parameter int MAX_HOLD = 51,
    localparam int LW = $clog2(MAX_HOLD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          claim,
    input  logic [LW-1:0] claim_len,
    output logic          busy
);

    typedef struct packed {
        logic [LW-1:0] left;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (claim) begin
            tmr_d.left = claim_len - LW'(1);
        end else if (tmr_q.left != '0) begin
            tmr_d.left = tmr_q.left - LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign busy = (tmr_q.left != '0);

    // R6
    claim_idle_chk: assert property (@(posedge clk) disable iff (rst)
        claim |-> !busy);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !busy);

endmodule

// File: rtl/hsb_arbiter.sv
module hsb_arbiter
    import hsb_pkg::*;
(
    input  logic                 v0,
    input  iclass_e              c0,
    input  logic                 v1,
    input  iclass_e              c1,
    input  logic [NUM_UNITS-1:0] busy,
    output logic                 g0,
    output logic                 g1,
    output logic [NUM_UNITS-1:0] claim,
    output logic [1:0]           store_on
);

    function automatic pick_t pick(iclass_e c, logic [NUM_UNITS-1:0] b);
        pick_t r;
        int    u;
        r = '0;
        case (c)
            CLS_NOP: r.ok = 1'b1;
            CLS_LOAD, CLS_STORE: begin
                if (!b[U_MEM0]) begin
                    r.ok = 1'b1;
                    r.claim[U_MEM0] = 1'b1;
                    r.store_on[0] = (c == CLS_STORE);
                end else if (!b[U_MEM1]) begin
                    r.ok = 1'b1;
                    r.claim[U_MEM1] = 1'b1;
                    r.store_on[1] = (c == CLS_STORE);
                end
            end
            default: begin
                u = single_unit(c);
                r.ok = !b[u];
                r.claim[u] = r.ok;
            end
        endcase
        return r;
    endfunction

    pick_t p0, p1;

    always_comb begin
        p0 = pick(c0, busy);
        g0 = v0 && p0.ok;
        p1 = pick(c1, busy | (g0 ? p0.claim : '0));
        g1 = g0 && v1 && p1.ok;
        claim    = (g0 ? p0.claim : '0) | (g1 ? p1.claim : '0);
        store_on = (g0 ? p0.store_on : 2'b00) | (g1 ? p1.store_on : 2'b00);
    end

endmodule

// File: rtl/issue_hazard_sb.sv
module issue_hazard_sb
    import hsb_pkg::*;
#(
    parameter int LOAD_HOLD  = 1,
    parameter int STORE_HOLD = 3,
    parameter int FMUL_HOLD  = 2,
    parameter int FDIV_HOLD  = 51,
    localparam int CW = $clog2(FDIV_HOLD + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slot0_valid,
    input  logic [2:0] slot0_class,
    input  logic       slot1_valid,
    input  logic [2:0] slot1_class,
    output logic       grant0,
    output logic       grant1,
    output logic [1:0] issue_count,
    output logic [6:0] unit_busy
);

    iclass_e              cls0, cls1;
    logic [NUM_UNITS-1:0] busy_q;
    logic [NUM_UNITS-1:0] claim_d;
    logic [1:0]           store_on_d;
    logic [CW-1:0]        len_d [NUM_UNITS];

    assign cls0 = iclass_e'(slot0_class);
    assign cls1 = iclass_e'(slot1_class);

    hsb_arbiter u_arb (
        .v0       (slot0_valid),
        .c0       (cls0),
        .v1       (slot1_valid),
        .c1       (cls1),
        .busy     (busy_q),
        .g0       (grant0),
        .g1       (grant1),
        .claim    (claim_d),
        .store_on (store_on_d)
    );

    always_comb begin
        len_d[U_MEM0] = store_on_d[0] ? CW'(STORE_HOLD) : CW'(LOAD_HOLD);
        len_d[U_MEM1] = store_on_d[1] ? CW'(STORE_HOLD) : CW'(LOAD_HOLD);
        len_d[U_ALU]  = CW'(1);
        len_d[U_FADD] = CW'(1);
        len_d[U_FMUL] = CW'(FMUL_HOLD);
        len_d[U_FDIV] = CW'(FDIV_HOLD);
        len_d[U_BR]   = CW'(1);
    end

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        hsb_unit_timer #(.MAX_HOLD(FDIV_HOLD)) u_tmr (
            .clk       (clk),
            .rst       (rst),
            .claim     (claim_d[i]),
            .claim_len (len_d[i]),
            .busy      (busy_q[i])
        );
    end

    assign issue_count = {1'b0, grant0} + {1'b0, grant1};
    assign unit_busy   = busy_q;

    // R2
    in_order_chk: assert property (@(posedge clk) disable iff (rst)
        grant1 |-> (grant0 && slot1_valid));

    // R3
    nop_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (slot0_valid && cls0 == CLS_NOP) |-> grant0);

    // R8
    div_lock_chk: assert property (@(posedge clk) disable iff (rst)
        unit_busy[U_FDIV] |-> !(grant0 && cls0 == CLS_FDIV));

    // R5
    store_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant0 && cls0 == CLS_STORE) |=> (unit_busy[U_MEM0] || unit_busy[U_MEM1]));

endmodule

// File: tb/issue_hazard_sb_test.sv
module issue_hazard_sb_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       v0 = 1'b0, v1 = 1'b0;
    logic [2:0] c0 = 3'd0, c1 = 3'd0;
    logic       grant0, grant1;
    logic [1:0] issue_count;
    logic [6:0] unit_busy;

    int checks = 0;
    int errors = 0;
    int rem [7];

    always #5 clk = ~clk;

    issue_hazard_sb uut (
        .clk (clk), .rst (rst),
        .slot0_valid (v0), .slot0_class (c0),
        .slot1_valid (v1), .slot1_class (c1),
        .grant0 (grant0), .grant1 (grant1),
        .issue_count (issue_count), .unit_busy (unit_busy)
    );

    function automatic int hold_of(int cls);
        case (cls)
            2: return 1;
            3: return 3;
            5: return 2;
            6: return 51;
            default: return 1;
        endcase
    endfunction

    function automatic int unit_of(int cls);
        case (cls)
            1: return 2;
            4: return 3;
            5: return 4;
            6: return 5;
            default: return 6;
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(string req, bit a0, int k0, bit a1, int k1);
        int  used [7];
        int  len  [7];
        bit  e0, e1;
        int  eb;
        @(negedge clk);
        v0 = a0; c0 = 3'(k0); v1 = a1; c1 = 3'(k1);
        #2;
        foreach (used[i]) used[i] = 0;
        e0 = 0; e1 = 0;
        for (int s = 0; s < 2; s++) begin
            int  k;
            bit  ok;
            k  = (s == 0) ? k0 : k1;
            ok = 0;
            if ((s == 0 && a0) || (s == 1 && e0 && a1)) begin
                if (k == 0) ok = 1;
                else if (k == 2 || k == 3) begin
                    for (int p = 0; p < 2; p++)
                        if (!ok && rem[p] == 0 && !used[p]) begin
                            ok = 1; used[p] = 1; len[p] = hold_of(k);
                        end
                end else if (rem[unit_of(k)] == 0 && !used[unit_of(k)]) begin
                    ok = 1; used[unit_of(k)] = 1; len[unit_of(k)] = hold_of(k);
                end
            end
            if (s == 0) e0 = ok; else e1 = ok;
        end
        eb = 0;
        for (int i = 0; i < 7; i++) if (rem[i] != 0) eb |= (1 << i);
        check(req, "grant0", int'(grant0), int'(e0));
        check(req, "grant1", int'(grant1), int'(e1));
        check("R1", "issue_count", int'(issue_count), int'(e0) + int'(e1));
        check("R10", "unit_busy", int'(unit_busy), eb);
        for (int i = 0; i < 7; i++) begin
            if (used[i]) rem[i] = len[i] - 1;
            else if (rem[i] > 0) rem[i]--;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; v0 = 0; v1 = 0;
        @(negedge clk);
        rst = 1'b0;
        foreach (rem[i]) rem[i] = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        foreach (rem[i]) rem[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: all free after reset
        step("R9", 0, 0, 0, 0);
        // R3: nop pairs
        step("R3", 1, 0, 1, 0);
        step("R2", 0, 1, 1, 1);
        // R4: two loads, then loads each cycle
        step("R4", 1, 2, 1, 2);
        step("R4", 1, 2, 1, 2);
        // R5: store holds a port for three cycles
        step("R5", 1, 3, 0, 0);
        step("R5", 1, 2, 1, 2);
        step("R5", 1, 3, 1, 3);
        step("R5", 1, 2, 0, 0);
        step("R5", 1, 2, 1, 2);
        step("R5", 1, 2, 1, 2);
        // R6: single-cycle units
        step("R6", 1, 1, 1, 1);
        step("R6", 1, 1, 1, 4);
        step("R6", 1, 7, 1, 7);
        step("R6", 1, 4, 1, 7);
        // R7: multiplier for two cycles
        step("R7", 1, 5, 0, 0);
        step("R7", 1, 5, 1, 1);
        step("R7", 1, 5, 0, 0);
        // R2: stalled slot0 blocks slot1
        step("R2", 1, 5, 1, 1);
        step("R2", 1, 1, 1, 5);
        // R8: divider 51 cycles
        step("R8", 1, 6, 0, 0);
        for (int n = 0; n < 55; n++) step("R8", 1, 6, 1, 1);
        // R9: reset mid-divide frees divider
        step("R9", 1, 6, 0, 0);
        do_reset();
        step("R9", 1, 6, 0, 0);
        // R1: random class stream
        for (int n = 0; n < 3000; n++)
            step("R1", 1'($urandom_range(0, 9) != 0), $urandom_range(0, 7),
                       1'($urandom_range(0, 3) != 0), $urandom_range(0, 7));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule